// File: doc/BRIEF.md
# Large-Block Address Translation Matcher

This block maps a 32-bit effective address straight to a real address through a small set of programmable block descriptors, without walking any page table. Each descriptor is a pair of 32-bit words: an upper word that says which address region it covers and in which privilege modes it applies, and a lower word that gives the real region and the access permissions. Instruction fetches and data accesses each have their own set of descriptors.

A variable-length mask in the upper word widens the block. It hides address bits from the comparison, and those bits are merged into the real address. A lookup is presented for one cycle. One cycle later the block reports whether a descriptor hit, the translated address, the permission set of the winning descriptor, and whether the requested access is allowed. Descriptors are loaded one word at a time through a simple write port.

Top module: `lbt_matcher`

## Requirements
- R1: After reset every descriptor word is zero and the response outputs are zero, so any lookup before a write misses.
- R2: The response appears on the cycle after a request (`req_valid` high at a clock edge) with `rsp_valid` high. `rsp_valid` is low in every other cycle.
- R3: An upper word holds the region tag in bits 31:28, the block index in bits 27:17 and the length mask in bits 12:2, where mask bit k covers address bit k+15. An address matches when its bits 31:28 equal the tag and its bits 27:17, with the masked positions cleared, equal the block index.
- R4: Upper bit 1 enables the descriptor for supervisor lookups (`req_user`=0) and upper bit 0 enables it for user lookups (`req_user`=1).
- R5: Lower bits 1:0 select the permissions, reported on `rsp_perm` as {exec, write, read}. Value 0 gives 3'b000, value 2 gives 3'b111, and values 1 and 3 give 3'b101.
- R6: `rsp_grant` is high only on a hit whose permissions include the requested access: exec for a fetch, write for a data store, read for a data load.
- R7: On a hit the real address is lower bits 31:28, then (address bits 27:17 AND mask) OR lower bits 27:17, then address bits 16:0 unchanged.
- R8: When several enabled descriptors match, the lowest index wins. This holds even when the winner denies the access.
- R9: A descriptor whose address matches but which is not enabled for the current mode is passed over, and a higher-index descriptor may then hit.
- R10: Fetches (`req_fetch`=1) search only the instruction set and data accesses only the data set.
- R11: A write stores `wr_data` into the set chosen by `wr_fetch` (1 = instruction), at the entry `wr_idx`, into the upper word when `wr_hi`=1 and the lower word otherwise. Lookups see the new word from the next cycle on.
- R12: On a miss, `rsp_hit`, `rsp_grant`, `rsp_perm` and `rsp_raddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor word write strobe |
| wr_fetch | input | 1 | Write target set: 1 instruction, 0 data |
| wr_idx | input | 2 | Descriptor index to write |
| wr_hi | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Effective address |
| req_fetch | input | 1 | 1 for instruction fetch |
| req_store | input | 1 | 1 for data store (ignored on fetch) |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_hit | output | 1 | A descriptor matched and was enabled |
| rsp_grant | output | 1 | Requested access allowed |
| rsp_perm | output | 3 | Winning permissions {exec, write, read} |
| rsp_raddr | output | 32 | Translated real address |

## Verification
A corrupted descriptor word shows up on the first lookup that reaches it. Depending on which field is damaged, the response one cycle later carries a wrong hit flag, a wrong real address or a wrong permission set. A bad priority or mode decision appears when two descriptors overlap. The wrong index then wins, or a descriptor that is not enabled shadows a valid one, and that is visible in the real address and the permissions of that same response. Loss of set separation shows as a hit for a fetch through a descriptor that exists only in the data set, or the other way round.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
    localparam int AW      = 32;
    localparam int TAG_HI  = 31;
    localparam int TAG_LO  = 28;
    localparam int BLK_HI  = 27;
    localparam int BLK_LO  = 17;
    localparam int BLK_W   = BLK_HI - BLK_LO + 1;
    localparam int LEN_LO  = 2;
    localparam int LEN_HI  = LEN_LO + BLK_W - 1;
    localparam int SUP_BIT = 1;
    localparam int USR_BIT = 0;

    // permission bits {exec, write, read}
    typedef logic [2:0] perm_t;
    localparam perm_t PERM_R = 3'b001;
    localparam perm_t PERM_W = 3'b010;
    localparam perm_t PERM_X = 3'b100;

    typedef struct packed {
        logic          hit;
        perm_t         perm;
        logic [AW-1:0] raddr;
    } lookup_t;

    function automatic perm_t decode_pp(input logic [1:0] pp);
        case (pp)
            2'd0:    return 3'b000;
            2'd2:    return PERM_R | PERM_W | PERM_X;
            default: return PERM_R | PERM_X;
        endcase
    endfunction
endpackage

// File: rtl/lbt_regfile.sv
module lbt_regfile #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_fetch,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       wr_hi,
    input  logic [31:0]                wr_data,
    input  logic                       rd_fetch,
    output logic [NUM_ENT-1:0][31:0]   rd_upper,
    output logic [NUM_ENT-1:0][31:0]   rd_lower
);
    typedef struct packed {
        logic [1:0][NUM_ENT-1:0][31:0] up;
        logic [1:0][NUM_ENT-1:0][31:0] lo;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (32'(wr_idx) < NUM_ENT)) begin
            if (wr_hi) begin
                bank_d.up[wr_fetch][wr_idx] = wr_data;
            end else begin
                bank_d.lo[wr_fetch][wr_idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_upper = bank_q.up[rd_fetch];
    assign rd_lower = bank_q.lo[rd_fetch];
endmodule

// File: rtl/lbt_entry_cmp.sv
module lbt_entry_cmp
    import lbt_pkg::*;
(
    input  logic [AW-1:0] upper,
    input  logic [AW-1:0] lower,
    input  logic [AW-1:0] addr,
    input  logic          user,
    output lookup_t       res
);
    logic [BLK_W-1:0] len_mask;
    logic             tag_eq;
    logic             blk_eq;
    logic             mode_ok;
    logic             unused_bits;

    assign len_mask    = upper[LEN_HI:LEN_LO];
    assign tag_eq      = (addr[TAG_HI:TAG_LO] == upper[TAG_HI:TAG_LO]);
    assign blk_eq      = ((addr[BLK_HI:BLK_LO] & ~len_mask) == upper[BLK_HI:BLK_LO]);
    assign mode_ok     = user ? upper[USR_BIT] : upper[SUP_BIT];
    assign unused_bits = ^{upper[BLK_LO-1:LEN_HI+1], lower[BLK_LO-1:2]};

    always_comb begin
        res.hit   = tag_eq & blk_eq & mode_ok;
        res.perm  = decode_pp(lower[1:0]);
        res.raddr = {lower[TAG_HI:TAG_LO],
                     (addr[BLK_HI:BLK_LO] & len_mask) | lower[BLK_HI:BLK_LO],
                     addr[BLK_LO-1:0]};
    end
endmodule

// File: rtl/lbt_prio_sel.sv
module lbt_prio_sel
    import lbt_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  lookup_t [NUM_ENT-1:0] cand,
    output lookup_t               pick
);
    always_comb begin
        pick = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (cand[i].hit) begin
                pick = cand[i];
            end
        end
    end
endmodule

// File: rtl/lbt_matcher.sv
module lbt_matcher
    import lbt_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_fetch,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic             req_valid,
    input  logic [31:0]      req_addr,
    input  logic             req_fetch,
    input  logic             req_store,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_grant,
    output logic [2:0]       rsp_perm,
    output logic [31:0]      rsp_raddr
);
    typedef struct packed {
        logic    vld;
        logic    ok;
        lookup_t res;
    } rsp_t;

    logic [NUM_ENT-1:0][31:0] upper_w;
    logic [NUM_ENT-1:0][31:0] lower_w;
    lookup_t [NUM_ENT-1:0]    cand;
    lookup_t                  pick;
    perm_t                    need;
    rsp_t                     rsp_d, rsp_q;

    lbt_regfile #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_fetch (wr_fetch),
        .wr_idx   (wr_idx),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .rd_fetch (req_fetch),
        .rd_upper (upper_w),
        .rd_lower (lower_w)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        lbt_entry_cmp u_cmp (
            .upper (upper_w[g]),
            .lower (lower_w[g]),
            .addr  (req_addr),
            .user  (req_user),
            .res   (cand[g])
        );
    end

    lbt_prio_sel #(.NUM_ENT(NUM_ENT)) u_prio (
        .cand (cand),
        .pick (pick)
    );

    always_comb begin
        need  = req_fetch ? PERM_X : (req_store ? PERM_W : PERM_R);
        rsp_d = '0;
        rsp_d.vld = req_valid;
        if (req_valid) begin
            rsp_d.res = pick;
            rsp_d.ok  = pick.hit & (|(pick.perm & need));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_hit   = rsp_q.res.hit;
    assign rsp_grant = rsp_q.ok;
    assign rsp_perm  = rsp_q.res.perm;
    assign rsp_raddr = rsp_q.res.raddr;
endmodule

// File: rtl/lbt_matcher_chk.sv
module lbt_matcher_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_fetch,
    input logic [IDX_W-1:0] wr_idx,
    input logic             wr_hi,
    input logic [31:0]      wr_data,
    input logic             req_valid,
    input logic [31:0]      req_addr,
    input logic             req_fetch,
    input logic             req_store,
    input logic             req_user,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_grant,
    input logic [2:0]       rsp_perm,
    input logic [31:0]      rsp_raddr
);
    // R2: a response only follows a request
    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R6: access granted only on a hit
    p_grant_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_hit);

    // R5: permission sets are limited to the three legal shapes
    p_perm_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_perm == 3'b000 || rsp_perm == 3'b101 || rsp_perm == 3'b111));

    // R7: low address bits pass through on a hit
    p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_raddr[16:0] == $past(req_addr[16:0])));

    // R12: a miss reports nothing
    p_miss_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_perm == 3'b000 && rsp_raddr == 32'd0 && !rsp_grant));

    // R6: a store that is granted carries write permission
    p_store_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_grant && $past(req_store) && !$past(req_fetch)) |-> rsp_perm[1]);

    logic unused_chk;
    assign unused_chk = ^{wr_en, wr_fetch, wr_idx, wr_hi, wr_data, req_user};
endmodule

bind lbt_matcher lbt_matcher_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/lbt_matcher_bench.sv
module lbt_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_fetch = 1'b0, wr_hi = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0, req_fetch = 1'b0, req_store = 1'b0, req_user = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_grant;
    logic [2:0]  rsp_perm;
    logic [31:0] rsp_raddr;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    lbt_matcher u_lbt_matcher (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_fetch(wr_fetch), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
        .req_store(req_store), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_grant(rsp_grant),
        .rsp_perm(rsp_perm), .rsp_raddr(rsp_raddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic fsel, input logic [1:0] idx, input logic hi, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_fetch = fsel; wr_idx = idx; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive one request, sample the response one cycle later
    task automatic look(input logic [31:0] a, input logic f, input logic s, input logic u);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_fetch = f; req_store = s; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic hit, input logic gr,
                              input logic [2:0] perm, input logic [31:0] ra);
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " hit"},   32'(rsp_hit),   32'(hit));
        chk({tag, " grant"}, 32'(rsp_grant), 32'(gr));
        chk({tag, " perm"},  32'(rsp_perm),  32'(perm));
        chk({tag, " raddr"}, rsp_raddr,      ra);
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 rsp_hit after reset",   32'(rsp_hit),   32'd0);
        look(32'h1000_0000, 1'b0, 1'b0, 1'b0);
        expect_rsp("R1 R12 empty lookup", 1'b0, 1'b0, 3'b000, 32'h0);
        @(negedge clk);
        chk("R2 no request no valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_basic;
        put(1'b0, 2'd0, 1'b1, 32'h1000_003E);   // tag 1, mask 0xF, supervisor only
        put(1'b0, 2'd0, 1'b0, 32'h8020_0002);   // read/write/exec
        look(32'h100B_4567, 1'b0, 1'b0, 1'b0);
        expect_rsp("R3 R7 R11 masked hit load", 1'b1, 1'b1, 3'b111, 32'h802B_4567);
        look(32'h100B_4567, 1'b0, 1'b1, 1'b0);
        expect_rsp("R6 store granted", 1'b1, 1'b1, 3'b111, 32'h802B_4567);
        look(32'h1020_0000, 1'b0, 1'b0, 1'b0);
        expect_rsp("R3 unmasked block bit differs", 1'b0, 1'b0, 3'b000, 32'h0);
        look(32'h200B_4567, 1'b0, 1'b0, 1'b0);
        expect_rsp("R3 tag differs", 1'b0, 1'b0, 3'b000, 32'h0);
        look(32'h100B_4567, 1'b0, 1'b0, 1'b1);
        expect_rsp("R4 user mode disabled", 1'b0, 1'b0, 3'b000, 32'h0);
        look(32'h100B_4567, 1'b1, 1'b0, 1'b0);
        expect_rsp("R10 fetch ignores data set", 1'b0, 1'b0, 3'b000, 32'h0);
    endtask

    task automatic t_skip_and_prio;
        put(1'b0, 2'd1, 1'b1, 32'h1000_0003);   // tag 1, no mask, both modes
        put(1'b0, 2'd1, 1'b0, 32'h4000_0001);   // read/exec
        look(32'h1001_2345, 1'b0, 1'b0, 1'b1);
        expect_rsp("R9 R4 user skips entry 0", 1'b1, 1'b1, 3'b101, 32'h4001_2345);
        look(32'h1001_2345, 1'b0, 1'b1, 1'b1);
        expect_rsp("R5 R6 store denied read-only", 1'b1, 1'b0, 3'b101, 32'h4001_2345);
        put(1'b0, 2'd0, 1'b0, 32'h8020_0000);   // entry 0 no access
        look(32'h1001_2345, 1'b0, 1'b0, 1'b0);
        expect_rsp("R8 R5 lowest index wins when denying", 1'b1, 1'b0, 3'b000, 32'h8021_2345);
    endtask

    task automatic t_fetch_set;
        put(1'b1, 2'd2, 1'b1, 32'h7000_1FFF);   // tag 7, full mask, both modes
        put(1'b1, 2'd2, 1'b0, 32'hC000_0003);
        look(32'h7ABC_DEF0, 1'b1, 1'b0, 1'b1);
        expect_rsp("R5 R7 fetch full mask", 1'b1, 1'b1, 3'b101, 32'hCABC_DEF0);
        look(32'h7ABC_DEF0, 1'b1, 1'b1, 1'b0);
        expect_rsp("R6 fetch ignores store flag", 1'b1, 1'b1, 3'b101, 32'hCABC_DEF0);
        look(32'h7ABC_DEF0, 1'b0, 1'b0, 1'b0);
        expect_rsp("R10 data ignores fetch set", 1'b0, 1'b0, 3'b000, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_skip_and_prio();
        t_fetch_set();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule